// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Register

This block keeps the stack pointer of a small 8-bit processor. The pointer is 16 bits wide and lives in the processor's I/O space as two byte registers, so software can read it or set it one byte at a time. The core raises one of four strobes: a data push, a data pop, a subroutine call (also used for interrupt entry) or a return (also used for interrupt exit). For each one the block moves the pointer and presents the first RAM address that the access touches.

The stack grows toward lower addresses. Byte-sized data operations move the pointer by one. Return-address operations move it by two. A push or a call writes at the current pointer and then moves it down. A pop or a return first moves the pointer up and then reads. Once software has written the pointer, a downward move that ends below the bottom of usable RAM raises a one-cycle error flag. The move is still carried out.

Top module: `stkp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer clears to 0x0000. After reset both pointer bytes read back as 0x00, and `stk_vld` and `stk_err` are low.
- R2: A push strobe reports address = pointer before the move, with `stk_wr`=1, and the pointer then drops by one.
- R3: A call strobe reports address = pointer before the move, with `stk_wr`=1, and the pointer then drops by two.
- R4: A pop strobe raises the pointer by one and reports the new pointer as the address, with `stk_wr`=0.
- R5: A return strobe raises the pointer by two and reports the old pointer plus one as the address, with `stk_wr`=0. Arithmetic wraps modulo 2^16.
- R6: I/O address 0x3D holds the low pointer byte and 0x3E holds the high byte. A write replaces only the addressed byte. `io_rdata` shows the addressed byte one cycle later, as it was before that cycle's update. Any other address reads 0x00, and a write to it changes nothing.
- R7: When a write to either pointer byte falls in the same cycle as a stack strobe, the write takes effect and the strobe is dropped: no `stk_vld` pulse, no error and no pointer move.
- R8: When several strobes are high together, the one that acts is chosen in this order: call, return, push, pop.
- R9: After the pointer has been written, a push or call whose result would fall below 0x0060, or wrap below zero, raises `stk_err` together with its `stk_vld` pulse. The pointer still moves.
- R10: From reset until the first write to a pointer byte, `stk_err` stays low for every operation.
- R11: `stk_vld`, `stk_wr`, `stk_addr` and `stk_err` are registered. They reflect the strobe sampled at the previous edge, and `stk_vld` is high for exactly one cycle per accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O register address for reads and writes |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| push_i | input | 1 | Data push strobe |
| pop_i | input | 1 | Data pop strobe |
| call_i | input | 1 | Call or interrupt entry strobe |
| ret_i | input | 1 | Return or interrupt exit strobe |
| stk_addr | output | 16 | First RAM address of the stack access |
| stk_vld | output | 1 | One-cycle pulse for an accepted stack access |
| stk_wr | output | 1 | Access is a write (push or call) |
| stk_err | output | 1 | Stack fell below the RAM floor |

## Verification
Two functions can land on the same edge: a software write to a pointer byte and a stack strobe from the core. The bench provokes this by raising `io_wr` to a pointer byte and a pop strobe at the same edge. It then requires that no access pulse appears. It reads both bytes back to confirm that the new byte was loaded and the other byte was kept. Several strobes raised together are judged the same way, against the expected priority winner.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_PUSH, OP_POP, OP_CALL, OP_RET} stk_op_e;

  typedef struct packed {
    logic active;
    logic down;
    logic wide;
  } op_ctl_t;
endpackage

// File: rtl/stkp_opsel.sv
module stkp_opsel
  import stkp_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    call_i,
  input  logic    ret_i,
  output op_ctl_t ctl
);
  stk_op_e op;

  // fixed priority: call, ret, push, pop
  always_comb begin
    if (call_i)      op = OP_CALL;
    else if (ret_i)  op = OP_RET;
    else if (push_i) op = OP_PUSH;
    else if (pop_i)  op = OP_POP;
    else             op = OP_NONE;
  end

  always_comb begin
    ctl = '0;
    case (op)
      OP_PUSH: begin ctl.active = 1'b1; ctl.down = 1'b1; ctl.wide = 1'b0; end
      OP_CALL: begin ctl.active = 1'b1; ctl.down = 1'b1; ctl.wide = 1'b1; end
      OP_POP:  begin ctl.active = 1'b1; ctl.down = 1'b0; ctl.wide = 1'b0; end
      OP_RET:  begin ctl.active = 1'b1; ctl.down = 1'b0; ctl.wide = 1'b1; end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/stkp_arith.sv
module stkp_arith
  import stkp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int FLOOR = 'h60
) (
  input  logic [AW-1:0] sp,
  input  op_ctl_t       ctl,
  input  logic          armed,
  output logic [AW-1:0] sp_nxt,
  output logic [AW-1:0] addr,
  output logic          err
);
  logic [AW-1:0] step;
  logic [AW:0]   limit;

  assign step  = ctl.wide ? AW'(2) : AW'(1);
  // one bit wider so that floor + step never overflows
  assign limit = (AW+1)'(FLOOR) + {1'b0, step};

  always_comb begin
    if (ctl.down) begin
      sp_nxt = sp - step;
      addr   = sp;
      err    = armed && ({1'b0, sp} < limit);
    end else begin
      sp_nxt = sp + step;
      addr   = sp + AW'(1);
      err    = 1'b0;
    end
  end
endmodule

// File: rtl/stkp_iobus.sv
module stkp_iobus #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int IO_AW     = 6,
  parameter int BASE_ADDR = 'h3D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [DW-1:0]    io_wdata,
  input  logic [AW-1:0]    sp,
  output logic             hit_wr,
  output logic [AW-1:0]    sp_wr_val,
  output logic [DW-1:0]    io_rdata
);
  localparam int NB = AW / DW;

  logic [NB-1:0] sel;
  logic [NB-1:0] wr_hit;
  logic [DW-1:0] rd_mux;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign sel[i]    = (io_addr == IO_AW'(BASE_ADDR + i));
    assign wr_hit[i] = io_wr && sel[i];
    assign sp_wr_val[i*DW +: DW] = wr_hit[i] ? io_wdata : sp[i*DW +: DW];
  end

  assign hit_wr = |wr_hit;

  always_comb begin
    rd_mux = '0;
    for (int j = 0; j < NB; j++) begin
      if (sel[j]) rd_mux = rd_mux | sp[j*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else     io_rdata <= rd_mux;
  end
endmodule

// File: rtl/stkp_top.sv
module stkp_top
  import stkp_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int IO_AW     = 6,
  parameter int BASE_ADDR = 'h3D,
  parameter int FLOOR     = 'h60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [AW-1:0]    stk_addr,
  output logic             stk_vld,
  output logic             stk_wr,
  output logic             stk_err
);
  logic [AW-1:0] sp_q;
  logic          armed_q;
  op_ctl_t       ctl;
  logic [AW-1:0] sp_nxt;
  logic [AW-1:0] acc_addr;
  logic          acc_err;
  logic          hit_wr;
  logic [AW-1:0] sp_wr_val;

  stkp_opsel u_opsel (
    .push_i (push_i),
    .pop_i  (pop_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .ctl    (ctl)
  );

  stkp_arith #(.AW(AW), .FLOOR(FLOOR)) u_arith (
    .sp     (sp_q),
    .ctl    (ctl),
    .armed  (armed_q),
    .sp_nxt (sp_nxt),
    .addr   (acc_addr),
    .err    (acc_err)
  );

  stkp_iobus #(.AW(AW), .DW(DW), .IO_AW(IO_AW), .BASE_ADDR(BASE_ADDR)) u_io (
    .clk       (clk),
    .rst       (rst),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .sp        (sp_q),
    .hit_wr    (hit_wr),
    .sp_wr_val (sp_wr_val),
    .io_rdata  (io_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q     <= '0;
      armed_q  <= 1'b0;
      stk_addr <= '0;
      stk_vld  <= 1'b0;
      stk_wr   <= 1'b0;
      stk_err  <= 1'b0;
    end else begin
      stk_vld <= 1'b0;
      stk_err <= 1'b0;
      if (hit_wr) begin
        sp_q    <= sp_wr_val;
        armed_q <= 1'b1;
      end else if (ctl.active) begin
        sp_q     <= sp_nxt;
        stk_vld  <= 1'b1;
        stk_wr   <= ctl.down;
        stk_addr <= acc_addr;
        stk_err  <= acc_err;
      end
    end
  end
endmodule

// File: rtl/stkp_chk.sv
module stkp_chk #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int IO_AW     = 6,
  parameter int BASE_ADDR = 'h3D
) (
  input logic             clk,
  input logic             rst,
  input logic [IO_AW-1:0] io_addr,
  input logic             io_wr,
  input logic             push_i,
  input logic             pop_i,
  input logic             call_i,
  input logic             ret_i,
  input logic [AW-1:0]    sp_q,
  input logic [AW-1:0]    stk_addr,
  input logic             stk_vld,
  input logic             stk_wr,
  input logic             stk_err
);
  logic hit;
  logic any;
  assign hit = io_wr && ((io_addr == IO_AW'(BASE_ADDR)) || (io_addr == IO_AW'(BASE_ADDR + 1)));
  assign any = push_i || pop_i || call_i || ret_i;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (sp_q == '0 && !stk_vld && !stk_err)); // R1

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hit && push_i && !call_i && !ret_i) |=> (stk_vld && stk_wr && sp_q == AW'($past(sp_q) - AW'(1)) && stk_addr == $past(sp_q))); // R2

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hit && call_i) |=> (stk_vld && stk_wr && sp_q == AW'($past(sp_q) - AW'(2)) && stk_addr == $past(sp_q))); // R3

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hit && pop_i && !push_i && !call_i && !ret_i) |=> (stk_vld && !stk_wr && sp_q == AW'($past(sp_q) + AW'(1)) && stk_addr == sp_q)); // R4

  AST_RET_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hit && ret_i && !call_i) |=> (stk_vld && !stk_wr && sp_q == AW'($past(sp_q) + AW'(2)) && stk_addr == AW'($past(sp_q) + AW'(1)))); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |=> (!stk_vld && !stk_err)); // R7

  AST_ERR_ON_DOWN: assert property (@(posedge clk) disable iff (rst)
    stk_err |-> (stk_vld && stk_wr)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hit && !any) |=> ($stable(sp_q) && !stk_vld)); // R11
endmodule

bind stkp_top stkp_chk #(.AW(AW), .DW(DW), .IO_AW(IO_AW), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .push_i   (push_i),
  .pop_i    (pop_i),
  .call_i   (call_i),
  .ret_i    (ret_i),
  .sp_q     (sp_q),
  .stk_addr (stk_addr),
  .stk_vld  (stk_vld),
  .stk_wr   (stk_wr),
  .stk_err  (stk_err)
);

// File: tb/sim_stkp_top.sv
module sim_stkp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        push_i = 1'b0, pop_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [15:0] stk_addr;
  logic        stk_vld, stk_wr, stk_err;

  always #5 clk = ~clk;

  stkp_top u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .push_i(push_i), .pop_i(pop_i), .call_i(call_i), .ret_i(ret_i),
    .stk_addr(stk_addr), .stk_vld(stk_vld), .stk_wr(stk_wr), .stk_err(stk_err)
  );

  typedef struct {
    logic [15:0] a;
    logic        w;
    logic        e;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] msp = '0;
  bit          marm = 1'b0;
  bit          done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: compare each access pulse with the oldest expected item
  always @(negedge clk) begin
    if (!rst && stk_vld) begin
      if (q.size() == 0) begin
        chk("R7 unexpected access", 32'(stk_vld), 32'd0);
      end else begin
        exp_t it;
        it = q.pop_front();
        chk({it.tag, " addr"}, 32'(stk_addr), 32'(it.a));
        chk({it.tag, " dir"},  32'(stk_wr),   32'(it.w));
        chk({it.tag, " err"},  32'(stk_err),  32'(it.e));
      end
    end
  end

  // driver: predicts the access from the requirements, then strobes
  task automatic op(bit p, bit po, bit c, bit r, string tag);
    exp_t it;
    logic [15:0] step;
    bit down;
    down = c || (!r && p);
    step = (c || r) ? 16'd2 : 16'd1;
    it.tag = tag;
    if (down) begin
      it.a = msp; it.w = 1'b1;
      it.e = marm && ({1'b0, msp} < (17'h60 + {1'b0, step}));
      msp = msp - step;
    end else begin
      it.a = msp + 16'd1; it.w = 1'b0; it.e = 1'b0;
      msp = msp + step;
    end
    @(negedge clk);
    push_i = p; pop_i = po; call_i = c; ret_i = r;
    q.push_back(it);
    @(negedge clk);
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wr = 1'b1; io_wdata = d;
    if (a == 6'h3D) begin msp[7:0] = d;  marm = 1'b1; end
    if (a == 6'h3E) begin msp[15:8] = d; marm = 1'b1; end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    io_addr = a;
    @(negedge clk);
    chk(tag, 32'(io_rdata), 32'(exp));
  endtask

  // R7: register write and pop strobe on the same edge
  task automatic collide(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wr = 1'b1; io_wdata = d; pop_i = 1'b1;
    if (a == 6'h3D) msp[7:0] = d;
    marm = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; pop_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 vld", 32'(stk_vld), 0);
    chk("R1 err", 32'(stk_err), 0);
    rd(6'h3D, 8'h00, "R1 low byte");
    rd(6'h3E, 8'h00, "R1 high byte");

    // R10 unarmed: moves across zero raise no error
    op(1, 0, 0, 0, "R10 push");
    op(0, 1, 0, 0, "R10 pop");
    op(0, 0, 1, 0, "R10 call");
    op(0, 0, 0, 1, "R10 ret");

    // R6 byte registers
    wr(6'h3E, 8'h12);
    wr(6'h3D, 8'h80);
    rd(6'h3E, 8'h12, "R6 high");
    rd(6'h3D, 8'h80, "R6 low");
    wr(6'h3F, 8'hAA);
    rd(6'h3F, 8'h00, "R6 other addr");
    rd(6'h3D, 8'h80, "R6 untouched");

    // R2..R5 main function
    op(1, 0, 0, 0, "R2 push");
    op(1, 0, 0, 0, "R2 push");
    op(0, 0, 1, 0, "R3 call");
    op(0, 1, 0, 0, "R4 pop");
    op(0, 0, 0, 1, "R5 ret");
    op(0, 0, 1, 0, "R3 call");
    op(0, 0, 0, 1, "R5 ret");
    @(negedge clk);
    chk("R11 single pulse", 32'(stk_vld), 0);
    rd(6'h3D, msp[7:0], "R4 low after");
    rd(6'h3E, msp[15:8], "R5 high after");

    // R8 priority
    op(1, 1, 0, 0, "R8 push over pop");
    op(1, 1, 1, 1, "R8 call over all");
    op(1, 1, 0, 1, "R8 ret over push");

    // R7 collision
    collide(6'h3D, 8'h44);
    rd(6'h3D, 8'h44, "R7 low written");
    rd(6'h3E, msp[15:8], "R7 high kept");

    // R9 floor error
    wr(6'h3E, 8'h00);
    wr(6'h3D, 8'h61);
    op(1, 0, 0, 0, "R9 push at 0x61");
    op(1, 0, 0, 0, "R9 push at 0x60");
    rd(6'h3D, 8'h5F, "R9 move done");
    wr(6'h3D, 8'h62);
    op(0, 0, 1, 0, "R9 call at 0x62");
    op(0, 0, 1, 0, "R9 call at 0x60");
    op(0, 1, 0, 0, "R9 pop no err");
    wr(6'h3D, 8'h01);
    op(0, 0, 1, 0, "R9 call wrap");

    // R10 reset disarms
    @(negedge clk);
    rst = 1'b1; msp = '0; marm = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    op(0, 0, 1, 0, "R10 call after reset");

    repeat (3) @(negedge clk);
    chk("R11 queue drained", 32'(q.size()), 0);
    finish_up();
  end
endmodule